// File: doc/BRIEF.md
# Debug Coprocessor Hazard Interlock

This block sits in the issue stage of a single-issue pipeline and holds back instructions that would read or use debug-related coprocessor state too early. It only handles a few specific producers and consumers of that state. The producers are the memory barrier, writes to the debug exception PC, writes to the Debug register, and writes to two single Debug fields: the one that gates load/store access to the debug memory segment, and the one that enables imprecise exceptions. The decoder upstream sets one flag per instruction class, and the block sees only those flags plus an issue-valid strobe. It returns a stall request and a code naming the hazard that causes the stall.

Each producer class has its own small tracker, a two-state machine with a down-counter. When a producer actually issues, its tracker moves from `TRK_IDLE` to `TRK_WAIT` and loads the pair spacing minus one. When the count would reach zero, the tracker drops back to `TRK_IDLE`. If another producer of the same class issues while the tracker is in `TRK_WAIT`, the tracker reloads the count and stays in `TRK_WAIT`. Spacing is counted in clock cycles. Bubbles, stall cycles and explicit no-op issue slots all count toward it. An arbiter combines the tracker counts with the consumer flags. It raises the stall and reports the pending pair with the largest remaining count.

Top module: `dbg_hazard_interlock`

## Requirements
- R1: After reset, or while reset is asserted, all trackers are clear: `stall` is 0 and `hz_cause` is 0 whatever consumer flags are presented.
- R2: If a barrier (`prod_cls[0]`) issues in cycle t, then a debug return (`cons_cls[0]`), any load/store (`cons_cls[1]`) or a Debug register read (`cons_cls[3]`) presented in cycle t+1 is stalled. The same instruction presented in cycle t+2 issues. The cause codes are 1, 2 and 3 respectively.
- R3: A debug exception PC write (`prod_cls[1]`) stalls a debug exception PC read (`cons_cls[4]`) in the next cycle only, with cause 4.
- R4: A Debug register write (`prod_cls[2]`) stalls a debug return in the next cycle only, with cause 5.
- R5: A write of the debug-segment access field (`prod_cls[3]`) stalls a load/store that targets the debug segment (`cons_cls[2]`, presented together with `cons_cls[1]`) in the next two cycles, with cause 6.
- R6: A write of the imprecise-exception enable field (`prod_cls[4]`) stalls an instruction that can raise an imprecise exception (`cons_cls[5]`) in the next two cycles, with cause 7.
- R7: A consumer that is not paired with a pending producer is not stalled. Two examples: a debug return after a debug exception PC write, and a load/store outside the debug segment after a write of the access field.
- R8: Spacing counts cycles, not issued instructions. An empty issue slot (a no-op with `issue_vld` high and no flags) counts toward the spacing.
- R9: `stall` is 0 and `hz_cause` is 0 in any cycle with `issue_vld` low.
- R10: When several pairs are pending at once, `hz_cause` names the pair with the largest remaining count. Ties go to the lowest cause code. `hz_cause` is 0 whenever `stall` is 0.
- R11: A producer that issues while its tracker is already counting reloads the tracker to the full spacing.
- R12: Producer flags of a stalled instruction have no effect on any tracker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_vld | input | 1 | An instruction is presented for issue this cycle |
| prod_cls | input | 5 | Producer flags: 0 barrier, 1 debug PC write, 2 Debug write, 3 segment-access field write, 4 imprecise-enable field write |
| cons_cls | input | 6 | Consumer flags: 0 debug return, 1 load/store, 2 debug-segment load/store, 3 Debug read, 4 debug PC read, 5 imprecise-capable |
| stall | output | 1 | Hold the presented instruction this cycle |
| hz_cause | output | 3 | Pair causing the stall, 0 when none |

## Verification
The bench measures the exact stall window of every pair. A tracker that loads the full spacing instead of the spacing minus one would stall one cycle too many. A tracker that forgets to count empty issue slots would stall a dependent load/store that is already legal. The bench also pits two pending pairs against each other, once with equal remaining counts and once with different ones. A wrong arbiter would then report the lower code where the larger count should win, or the higher code on a tie. It checks that a second producer of the same class lengthens the window, which a non-reloading tracker would cut short. It also checks that a stalled instruction carrying a producer flag arms nothing, where a bad design would create a spurious stall on the next consumer.

// File: rtl/dbg_hz_pkg.sv
package dbg_hz_pkg;

    localparam int NPROD = 5;
    localparam int NCONS = 6;
    localparam int NPAIR = 7;

    typedef enum logic {
        TRK_IDLE,
        TRK_WAIT
    } trk_state_e;

    typedef enum logic [2:0] {
        HZ_NONE        = 3'd0,
        HZ_BAR_RET     = 3'd1,
        HZ_BAR_LDST    = 3'd2,
        HZ_BAR_DBGRD   = 3'd3,
        HZ_PCW_PCRD    = 3'd4,
        HZ_DBGW_RET    = 3'd5,
        HZ_SEGW_SEGLS  = 3'd6,
        HZ_IMPW_IMPR   = 3'd7
    } hz_cause_e;

    // pair p reports cause p+1; producer and consumer bit for each pair
    localparam int PAIR_PROD [NPAIR] = '{0, 0, 0, 1, 2, 3, 4};
    localparam int PAIR_CONS [NPAIR] = '{0, 1, 3, 4, 0, 2, 5};

endpackage

// File: rtl/dbg_hz_tracker.sv
module dbg_hz_tracker
    import dbg_hz_pkg::*;
#(
    parameter int GAP = 2,
    parameter int CW  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    output logic [CW-1:0] remain
);

    localparam logic [CW-1:0] RELOAD = CW'(GAP - 1);
    localparam bit            ARMS   = (GAP > 1);

    trk_state_e    state, state_nxt;
    logic [CW-1:0] cnt, cnt_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= TRK_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        unique case (state)
            TRK_IDLE: begin
                if (load && ARMS) begin
                    state_nxt = TRK_WAIT;
                    cnt_nxt   = RELOAD;
                end
            end
            TRK_WAIT: begin
                if (load) begin
                    cnt_nxt = RELOAD;
                end else if (cnt == CW'(1)) begin
                    state_nxt = TRK_IDLE;
                    cnt_nxt   = '0;
                end else begin
                    cnt_nxt = cnt - CW'(1);
                end
            end
            default: begin
                state_nxt = TRK_IDLE;
                cnt_nxt   = '0;
            end
        endcase
    end

    always_comb remain = cnt;

    AST_RELOAD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> remain == RELOAD); // R11

    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TRK_WAIT && !load) |=> remain == $past(remain) - CW'(1)); // R8

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        remain <= RELOAD); // R11

endmodule

// File: rtl/dbg_hz_arbiter.sv
module dbg_hz_arbiter
    import dbg_hz_pkg::*;
#(
    parameter int CW = 2
) (
    input  logic             issue_vld,
    input  logic [NCONS-1:0] cons_cls,
    input  logic [CW-1:0]    remain [NPROD],
    output logic             stall,
    output logic [2:0]       hz_cause
);

    logic [CW-1:0] best_cnt;

    always_comb begin
        best_cnt = '0;
        hz_cause = HZ_NONE;
        for (int p = 0; p < NPAIR; p++) begin
            if (issue_vld && cons_cls[PAIR_CONS[p]]
                && remain[PAIR_PROD[p]] > best_cnt) begin
                best_cnt = remain[PAIR_PROD[p]];
                hz_cause = 3'(p + 1);
            end
        end
        stall = (hz_cause != HZ_NONE);
    end

endmodule

// File: rtl/dbg_hazard_interlock.sv
module dbg_hazard_interlock
    import dbg_hz_pkg::*;
#(
    parameter int BAR_GAP  = 2,
    parameter int PCW_GAP  = 2,
    parameter int DBGW_GAP = 2,
    parameter int SEGW_GAP = 3,
    parameter int IMPW_GAP = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_vld,
    input  logic [NPROD-1:0] prod_cls,
    input  logic [NCONS-1:0] cons_cls,
    output logic             stall,
    output logic [2:0]       hz_cause
);

    localparam int GAPS [NPROD] = '{BAR_GAP, PCW_GAP, DBGW_GAP, SEGW_GAP, IMPW_GAP};
    localparam int MAXG_A = (BAR_GAP > PCW_GAP) ? BAR_GAP : PCW_GAP;
    localparam int MAXG_B = (DBGW_GAP > SEGW_GAP) ? DBGW_GAP : SEGW_GAP;
    localparam int MAXG_C = (MAXG_A > MAXG_B) ? MAXG_A : MAXG_B;
    localparam int MAXG   = (MAXG_C > IMPW_GAP) ? MAXG_C : IMPW_GAP;
    localparam int CW     = $clog2(MAXG + 1);

    logic [CW-1:0] remain [NPROD];
    logic          issued;

    assign issued = issue_vld && !stall;

    for (genvar g = 0; g < NPROD; g++) begin : g_trk
        dbg_hz_tracker #(
            .GAP (GAPS[g]),
            .CW  (CW)
        ) u_trk (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (issued && prod_cls[g]),
            .remain (remain[g])
        );
    end

    dbg_hz_arbiter #(
        .CW (CW)
    ) u_arb (
        .issue_vld (issue_vld),
        .cons_cls  (cons_cls),
        .remain    (remain),
        .stall     (stall),
        .hz_cause  (hz_cause)
    );

    AST_STALL_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> issue_vld); // R9

    AST_CAUSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !stall |-> hz_cause == 3'd0); // R10

    if (BAR_GAP > 1) begin : g_bar_chk
        AST_BAR_RET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (issued && prod_cls[0]) |=> (!(issue_vld && cons_cls[0]) || stall)); // R2
    end

    if (SEGW_GAP > 1) begin : g_seg_chk
        AST_SEG_LDST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (issued && prod_cls[3]) |=> (!(issue_vld && cons_cls[2]) || stall)); // R5
    end

endmodule

// File: tb/sim_dbg_hazard_interlock.sv
module sim_dbg_hazard_interlock;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       issue_vld = 1'b0;
    logic [4:0] prod_cls = '0;
    logic [5:0] cons_cls = '0;
    logic       stall;
    logic [2:0] hz_cause;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dbg_hazard_interlock u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue_vld (issue_vld),
        .prod_cls  (prod_cls),
        .cons_cls  (cons_cls),
        .stall     (stall),
        .hz_cause  (hz_cause)
    );

    // {req, valid, prod[4:0], cons[5:0], exp_stall, exp_cause}
    localparam int NV = 45;
    localparam logic [19:0] VEC [NV] = '{
        {4'd1,  16'b1_00000_000001_0_000}, // R1 fresh after reset
        {4'd2,  16'b1_00001_000000_0_000}, // R2 barrier
        {4'd2,  16'b1_00000_000001_1_001},
        {4'd2,  16'b1_00000_000001_0_000},
        {4'd2,  16'b1_00001_000000_0_000},
        {4'd2,  16'b1_00000_000010_1_010},
        {4'd2,  16'b1_00000_000010_0_000},
        {4'd2,  16'b1_00001_000000_0_000},
        {4'd2,  16'b1_00000_001000_1_011},
        {4'd2,  16'b1_00000_001000_0_000},
        {4'd3,  16'b1_00010_000000_0_000}, // R3
        {4'd3,  16'b1_00000_010000_1_100},
        {4'd3,  16'b1_00000_010000_0_000},
        {4'd4,  16'b1_00100_000000_0_000}, // R4
        {4'd4,  16'b1_00000_000001_1_101},
        {4'd4,  16'b1_00000_000001_0_000},
        {4'd5,  16'b1_01000_000000_0_000}, // R5
        {4'd5,  16'b1_00000_000110_1_110},
        {4'd5,  16'b1_00000_000110_1_110},
        {4'd5,  16'b1_00000_000110_0_000},
        {4'd7,  16'b1_01000_000000_0_000}, // R7 plain ldst after field write
        {4'd7,  16'b1_00000_000010_0_000},
        {4'd8,  16'b1_00000_000000_0_000}, // R8 empty slot counts
        {4'd8,  16'b1_00000_000110_0_000},
        {4'd7,  16'b1_00010_000000_0_000}, // R7 return after PC write
        {4'd7,  16'b1_00000_000001_0_000},
        {4'd6,  16'b1_10000_000000_0_000}, // R6
        {4'd9,  16'b0_00000_100000_0_000}, // R9 no valid
        {4'd6,  16'b1_00000_100000_1_111},
        {4'd6,  16'b1_00000_100000_0_000},
        {4'd10, 16'b1_01000_000000_0_000}, // R10 tie
        {4'd10, 16'b1_00001_000000_0_000},
        {4'd10, 16'b1_00000_000110_1_010},
        {4'd10, 16'b1_01001_000000_0_000}, // R10 largest wins
        {4'd10, 16'b1_00000_000110_1_110},
        {4'd10, 16'b1_00000_000110_1_110},
        {4'd10, 16'b1_00000_000110_0_000},
        {4'd11, 16'b1_10000_000000_0_000}, // R11 reload
        {4'd11, 16'b1_10000_000000_0_000},
        {4'd11, 16'b1_00000_100000_1_111},
        {4'd11, 16'b1_00000_100000_1_111},
        {4'd11, 16'b1_00000_100000_0_000},
        {4'd12, 16'b1_00001_000000_0_000}, // R12 stalled producer
        {4'd12, 16'b1_10000_000010_1_010},
        {4'd12, 16'b1_00000_100000_0_000}
    };

    task automatic check(input int req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [4:0] p, input logic [5:0] c);
        @(negedge clk);
        issue_vld = v;
        prod_cls  = p;
        cons_cls  = c;
        #1;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 outputs held clear during reset
        issue_vld = 1'b1;
        cons_cls  = 6'b111111;
        #1;
        check(1, "stall in reset", int'(stall), 0);
        check(1, "cause in reset", int'(hz_cause), 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][15], VEC[i][14:10], VEC[i][9:4]);
            check(int'(VEC[i][19:16]), $sformatf("row %0d stall", i), int'(stall), int'(VEC[i][3]));
            check(int'(VEC[i][19:16]), $sformatf("row %0d cause", i), int'(hz_cause), int'(VEC[i][2:0]));
        end

        // R1 reset in the middle of a count clears the tracker
        drive(1'b1, 5'b01000, 6'b000000);
        drive(1'b1, 5'b00000, 6'b000110);
        check(1, "pre-reset seg stall", int'(stall), 1);
        rst_n = 1'b0;
        #1;
        check(1, "reset clears stall", int'(stall), 0);
        drive(1'b0, 5'b00000, 6'b000000);
        rst_n = 1'b1;
        drive(1'b1, 5'b00000, 6'b000110);
        check(1, "after reset seg stall", int'(stall), 0);
        check(1, "after reset cause", int'(hz_cause), 0);

        // R9 bubbles while a barrier is pending, then R2 window already over
        drive(1'b1, 5'b00001, 6'b000000);
        drive(1'b0, 5'b00000, 6'b001011);
        check(9, "invalid slot stall", int'(stall), 0);
        check(9, "invalid slot cause", int'(hz_cause), 0);
        drive(1'b1, 5'b00000, 6'b001011);
        check(8, "barrier window elapsed", int'(stall), 0);

        drive(1'b0, 5'b00000, 6'b000000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule